// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital controller that sits beside a 10-bit successive-approximation converter core. Software programs one control/status word. The word holds a start bit, a two-bit mode field, a four-bit channel field, a done flag and an interrupt enable. The sequencer then runs one of three modes:

- **Single:** one conversion of the chosen channel.
- **Single-cycle scan:** one ascending pass over channels 0 up to the chosen channel.
- **Continuous scan:** passes repeat until software clears the start bit.

Each result lands in a per-channel result register. Any result can be read through a channel-select port.

Toward the analog core the block uses a minimal handshake. It gives a channel index and a one-cycle start pulse, and the core answers with a one-cycle done pulse that carries the data. A completed pass raises the done flag. The done flag drives the interrupt request when the enable is set. The flag clears in two ways: a read-then-write-zero sequence from software, or an acknowledge from a DMA engine that serviced the request. The read data of the control word is always visible. Only a cycle with the read strobe high counts as "having read the flag" for the clear rule.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads all zero, irq is 0, conv_start is 0 and every result register reads 0. The control word layout is: bit 0 start, bits 2:1 mode, bits 6:3 channel, bit 7 done, bit 8 interrupt enable.
- R2: Mode 00 (and the reserved 01) converts only the channel in the channel field, once. It then sets done and returns to idle.
- R3: Mode 10 converts channels 0,1,...,N once in ascending order, where N is the channel field. It sets done when channel N completes and then stops.
- R4: Mode 11 repeats ascending passes over 0..N and sets done at the end of each pass. Writing 0 to the start bit lets the conversion in flight finish, starts no further conversion, and makes the start bit read 0.
- R5: The start bit reads 1 from the accepted start write until the sequence ends. It clears itself when a mode 00/01/10 sequence completes and stays 1 during continuous scan.
- R6: Each completed conversion writes its data into the result register of the converted channel. No other result register changes.
- R7: irq is 1 exactly when the done flag and the interrupt enable are both 1.
- R8: Writing 0 to the done bit clears done only if a read strobe saw done as 1 after the flag was last set. Otherwise the write leaves done at 1. Writing 1 to the done bit never sets it.
- R9: A pulse on dma_ack clears the done flag.
- R10: A write of 1 to the start bit while a sequence is running is ignored. The running sequence keeps the mode and channel latched at its start.
- R11: Each conversion issues exactly one single-cycle conv_start. conv_ch holds the channel from that pulse until the core answers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_rd | input | 1 | Read strobe; marks a read that arms the done clear |
| csr_wdata | input | 9 | Control word write data |
| csr_rdata | output | 9 | Control word read data (always driven) |
| res_sel | input | 4 | Result register select |
| res_data | output | 10 | Selected result register |
| irq | output | 1 | Interrupt request |
| dma_ack | input | 1 | DMA acknowledge; clears the done flag |
| conv_start | output | 1 | One-cycle start pulse to the analog core |
| conv_ch | output | 4 | Channel for the current conversion |
| conv_done | input | 1 | One-cycle completion pulse from the analog core |
| conv_data | input | 10 | Conversion result, valid with conv_done |

## Verification
Single mode is swept over all sixteen channels. This separates a wrong channel index from a wrong result slot, because each channel gets a data value distinct from every other.

Single-cycle scans with end channels 0, 5 and 15 tell a correct ascending pass apart from an off-by-one end or a wrap. A continuous run over three channels is cut short part way through, which shows whether the stop waits for the conversion in flight and then goes quiet.

The done-flag tests cover three clear paths: a write of zero without a read, a read-then-write, and a DMA acknowledge. A start write during a running scan and a run with the enable cleared separate the ignore rule and the interrupt gating from the normal flow.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding, mode codes and control-word bit positions
// for the conversion sequencer. Positions above the channel field depend on
// the channel width and are derived in the modules that use them.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    localparam int unsigned BIT_START = 0;
    localparam int unsigned MODE_LSB  = 1;
    localparam int unsigned MODE_W    = 2;
    localparam int unsigned CHAN_LSB  = MODE_LSB + MODE_W;

    localparam logic [1:0] MODE_SINGLE    = 2'b00;
    localparam logic [1:0] MODE_SCAN_ONCE = 2'b10;
    localparam logic [1:0] MODE_SCAN_LOOP = 2'b11;

endpackage

// File: rtl/adc_csr.sv
// Module: adc_csr
// Holds the control/status word: start bit, mode and channel fields, done
// flag with its read-then-clear arming, and the interrupt enable. Decodes
// software writes into launch and stop requests for the sequencer.
// Assumes seq_pass_done and seq_finish are single-cycle pulses and that
// seq_busy is high from the cycle after launch until the sequence ends.
module adc_csr #(
    parameter int unsigned CH_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_wr,
    input  logic                      csr_rd,
    input  logic [CH_W+4:0]           csr_wdata,
    output logic [CH_W+4:0]           csr_rdata,
    input  logic                      dma_ack,
    input  logic                      seq_busy,
    input  logic                      seq_pass_done,
    input  logic                      seq_finish,
    output logic                      launch,
    output logic                      stop_req,
    output logic [1:0]                go_mode,
    output logic [CH_W-1:0]           go_chan,
    output logic                      irq
);
    import adc_seq_pkg::*;

    localparam int unsigned DONE_BIT = CHAN_LSB + CH_W;
    localparam int unsigned IE_BIT   = DONE_BIT + 1;

    logic            start_q;
    logic [1:0]      mode_q;
    logic [CH_W-1:0] chan_q;
    logic            done_q;
    logic            armed_q;
    logic            ie_q;

    logic wr_start;
    logic wr_done;
    logic done_clr;

    // Decode write fields and the requests they make.
    always_comb begin
        wr_start = csr_wdata[BIT_START];
        wr_done  = csr_wdata[DONE_BIT];
        go_mode  = csr_wdata[MODE_LSB +: MODE_W];
        go_chan  = csr_wdata[CHAN_LSB +: CH_W];
        launch   = csr_wr && wr_start && !seq_busy;
        stop_req = csr_wr && !wr_start && seq_busy;
        done_clr = dma_ack || (csr_wr && !wr_done && armed_q);
    end

    // Start bit: set on an accepted launch, cleared by software or at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else if (launch) begin
            start_q <= 1'b1;
        end else if (csr_wr && !wr_start) begin
            start_q <= 1'b0;
        end else if (seq_finish) begin
            start_q <= 1'b0;
        end
    end

    // Plain configuration fields, written on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            chan_q <= '0;
            ie_q   <= 1'b0;
        end else if (csr_wr) begin
            mode_q <= go_mode;
            chan_q <= go_chan;
            ie_q   <= csr_wdata[IE_BIT];
        end
    end

    // Done flag: a completed pass wins over any clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (seq_pass_done) begin
            done_q <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    // Arm the software clear once a strobed read has seen the flag at 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (seq_pass_done || done_clr) begin
            armed_q <= 1'b0;
        end else if (csr_rd && done_q) begin
            armed_q <= 1'b1;
        end
    end

    // Assemble the read word and the interrupt request.
    always_comb begin
        csr_rdata                        = '0;
        csr_rdata[BIT_START]             = start_q;
        csr_rdata[MODE_LSB +: MODE_W]    = mode_q;
        csr_rdata[CHAN_LSB +: CH_W]      = chan_q;
        csr_rdata[DONE_BIT]              = done_q;
        csr_rdata[IE_BIT]                = ie_q;
        irq                              = done_q && ie_q;
    end

endmodule

// File: rtl/adc_sequencer.sv
// Module: adc_sequencer
// Walks the conversion order for the latched mode and channel, drives the
// start/done handshake to the analog core and reports pass ends and finish.
// Assumes the core answers each conv_start with exactly one conv_done.
module adc_sequencer #(
    parameter int unsigned CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic            stop_req,
    input  logic [1:0]      go_mode,
    input  logic [CH_W-1:0] go_chan,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_ch,
    output logic            busy,
    output logic            pass_done,
    output logic            finish,
    output logic            res_we
);
    import adc_seq_pkg::*;

    sq_state_e       state_q;
    logic [1:0]      mode_q;
    logic [CH_W-1:0] cur_q;
    logic [CH_W-1:0] last_q;
    logic            abort_q;

    logic done_evt;
    logic at_last;
    logic looping;

    // Completion decode for the conversion in flight.
    always_comb begin
        done_evt   = (state_q == SQ_WAIT) && conv_done;
        at_last    = (cur_q == last_q);
        looping    = (mode_q == MODE_SCAN_LOOP);
        pass_done  = done_evt && at_last;
        finish     = done_evt && (abort_q || stop_req || (at_last && !looping));
        busy       = (state_q != SQ_IDLE);
        conv_start = (state_q == SQ_REQ);
        conv_ch    = cur_q;
        res_we     = done_evt;
    end

    // Sequencing state, channel walk and stop request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            mode_q  <= MODE_SINGLE;
            cur_q   <= '0;
            last_q  <= '0;
            abort_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (launch) begin
                        mode_q  <= go_mode;
                        last_q  <= go_chan;
                        cur_q   <= go_mode[1] ? '0 : go_chan;
                        abort_q <= 1'b0;
                        state_q <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    state_q <= SQ_WAIT;
                    if (stop_req) abort_q <= 1'b1;
                end
                SQ_WAIT: begin
                    if (stop_req) abort_q <= 1'b1;
                    if (conv_done) begin
                        if (finish) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            cur_q   <= at_last ? '0 : cur_q + 1'b1;
                            state_q <= SQ_REQ;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
// Module: adc_result_bank
// One result register per channel, written by the sequencer on completion
// and read through a channel select. Assumes at most one write per cycle.
module adc_result_bank #(
    parameter int unsigned CH_W  = 4,
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);
    localparam int unsigned NUM_CH = 1 << CH_W;

    logic [RES_W-1:0] bank [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [RES_W-1:0] slot_q;

        // Capture the result addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we && (wr_ch == CH_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign bank[g] = slot_q;
    end

    // Select the requested slot for reading.
    always_comb rd_data = bank[rd_ch];

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// Conversion mode sequencer: control word, sequencer and per-channel result
// storage around an external successive-approximation core.
// Assumes the core's conv_done arrives at least one cycle after conv_start.
module adc_seq_ctrl #(
    parameter int unsigned CH_W  = 4,
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic             csr_rd,
    input  logic [CH_W+4:0]  csr_wdata,
    output logic [CH_W+4:0]  csr_rdata,
    input  logic [CH_W-1:0]  res_sel,
    output logic [RES_W-1:0] res_data,
    output logic             irq,
    input  logic             dma_ack,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_ch,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data
);
    logic            launch;
    logic            stop_req;
    logic [1:0]      go_mode;
    logic [CH_W-1:0] go_chan;
    logic            seq_busy;
    logic            seq_pass_done;
    logic            seq_finish;
    logic            res_we;

    adc_csr #(.CH_W(CH_W)) csr_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .csr_wr        (csr_wr),
        .csr_rd        (csr_rd),
        .csr_wdata     (csr_wdata),
        .csr_rdata     (csr_rdata),
        .dma_ack       (dma_ack),
        .seq_busy      (seq_busy),
        .seq_pass_done (seq_pass_done),
        .seq_finish    (seq_finish),
        .launch        (launch),
        .stop_req      (stop_req),
        .go_mode       (go_mode),
        .go_chan       (go_chan),
        .irq           (irq)
    );

    adc_sequencer #(.CH_W(CH_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .stop_req   (stop_req),
        .go_mode    (go_mode),
        .go_chan    (go_chan),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .busy       (seq_busy),
        .pass_done  (seq_pass_done),
        .finish     (seq_finish),
        .res_we     (res_we)
    );

    adc_result_bank #(.CH_W(CH_W), .RES_W(RES_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (res_we),
        .wr_ch   (conv_ch),
        .wr_data (conv_data),
        .rd_ch   (res_sel),
        .rd_data (res_data)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Module: adc_seq_ctrl_chk
// Temporal checks on the sequencer's ports, bound into adc_seq_ctrl.
module adc_seq_ctrl_chk #(
    parameter int unsigned CH_W  = 4,
    parameter int unsigned RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr,
    input logic [CH_W+4:0]  csr_wdata,
    input logic [CH_W+4:0]  csr_rdata,
    input logic [CH_W-1:0]  res_sel,
    input logic [RES_W-1:0] res_data,
    input logic             irq,
    input logic             dma_ack,
    input logic             conv_start,
    input logic [CH_W-1:0]  conv_ch,
    input logic             conv_done
);
    localparam int unsigned DONE_BIT = 3 + CH_W;
    localparam int unsigned IE_BIT   = DONE_BIT + 1;

    p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_ch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(conv_ch));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[DONE_BIT] && !dma_ack && !csr_wr) |=> csr_rdata[DONE_BIT]);

    p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !conv_done) |=> !csr_rdata[DONE_BIT]);

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csr_rdata[DONE_BIT]) && csr_rdata[IE_BIT]) |-> irq);

    p_bank_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> (!$stable(res_sel) || $stable(res_data)));

    p_busy_go_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[0] && csr_wr && csr_wdata[0]) |=> csr_rdata[0]);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W), .RES_W(RES_W)) chk_i (.*);

// File: tb/adc_seq_ctrl_tb_top.sv
// Bench: adc_seq_ctrl_tb_top
// Sweeps modes and channels against a behavioural conversion-core stub and
// checks results, ordering and flag behaviour from the requirements.
module adc_seq_ctrl_tb_top;
    localparam int CH_W  = 4;
    localparam int RES_W = 10;
    localparam int NCH   = 1 << CH_W;
    localparam int LAT   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csr_wr = 1'b0;
    logic             csr_rd = 1'b0;
    logic [CH_W+4:0]  csr_wdata = '0;
    logic [CH_W+4:0]  csr_rdata;
    logic [CH_W-1:0]  res_sel = '0;
    logic [RES_W-1:0] res_data;
    logic             irq;
    logic             dma_ack = 1'b0;
    logic             conv_start;
    logic [CH_W-1:0]  conv_ch;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_data = '0;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;
    int run    = 0;
    int ncv    = 0;
    int pend   = 0;
    int cur_ch = 0;
    int log_ch [64];
    int exp_res [NCH];

    always #4 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .res_sel(res_sel),
        .res_data(res_data), .irq(irq), .dma_ack(dma_ack),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data)
    );

    function automatic int fval(input int ch, input int r);
        return (ch * 61 + r * 17 + 5) % 1024;
    endfunction

    function automatic logic [8:0] mk(input logic s, input logic [1:0] m,
                                      input logic [3:0] c, input logic d,
                                      input logic e);
        return {e, d, c, m, s};
    endfunction

    // Behavioural core stub and start-pulse monitor, away from the active edge.
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (pend != 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                conv_done = 1'b1;
                conv_data = RES_W'(fval(cur_ch, run));
            end
        end
        if (rst_n && conv_start) begin
            if (ncv < 64) log_ch[ncv] = int'(conv_ch);
            ncv    = ncv + 1;
            cur_ch = int'(conv_ch);
            pend   = LAT;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic csr_write(input logic [8:0] v);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read();
        @(negedge clk);
        csr_rd = 1'b1;
        @(negedge clk);
        csr_rd = 1'b0;
    endtask

    task automatic pulse_dma();
        @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic wait_done();
        while (!csr_rdata[7]) @(negedge clk);
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        for (int c = 0; c < NCH; c++) begin
            res_sel = CH_W'(c);
            #1;
            chk(req, int'(res_data), exp_res[c]);
        end
    endtask

    task automatic check_order(input string req, input int last, input int n);
        for (int i = 0; i < n && i < 64; i++)
            chk(req, log_ch[i], i % (last + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NCH; c++) exp_res[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 csr", int'(csr_rdata), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 conv_start", int'(conv_start), 0);
        check_bank("R1 bank");

        // R2/R5/R7/R8/R11: single mode over every channel.
        for (int ch = 0; ch < NCH; ch++) begin
            run++; ncv = 0;
            csr_write(mk(1'b1, 2'b00, 4'(ch), 1'b0, 1'b1));
            chk("R5 start busy", int'(csr_rdata[0]), 1);
            wait_done();
            exp_res[ch] = fval(ch, run);
            chk("R2 count", ncv, 1);
            chk("R11 channel", log_ch[0], ch);
            chk("R5 start cleared", int'(csr_rdata[0]), 0);
            chk("R7 irq set", int'(irq), 1);
            csr_write(mk(1'b0, 2'b00, 4'(ch), 1'b0, 1'b1));
            chk("R8 no-read clear ignored", int'(csr_rdata[7]), 1);
            csr_read();
            csr_write(mk(1'b0, 2'b00, 4'(ch), 1'b0, 1'b1));
            chk("R8 cleared", int'(csr_rdata[7]), 0);
            chk("R7 irq low", int'(irq), 0);
        end
        check_bank("R6 single bank");

        // R3/R9: single-cycle scans with several end channels.
        for (int k = 0; k < 3; k++) begin
            automatic int last = (k == 0) ? 0 : (k == 1) ? 5 : 15;
            run++; ncv = 0;
            csr_write(mk(1'b1, 2'b10, 4'(last), 1'b0, 1'b1));
            wait_done();
            for (int c = 0; c <= last; c++) exp_res[c] = fval(c, run);
            chk("R3 count", ncv, last + 1);
            check_order("R3 order", last, ncv);
            chk("R5 scan start cleared", int'(csr_rdata[0]), 0);
            check_bank("R6 scan bank");
            pulse_dma();
            chk("R9 dma clear", int'(csr_rdata[7]), 0);
            chk("R9 irq low", int'(irq), 0);
        end

        // R10: start write during a running scan is ignored.
        run++; ncv = 0;
        csr_write(mk(1'b1, 2'b10, 4'd15, 1'b0, 1'b1));
        while (ncv < 3) @(negedge clk);
        csr_write(mk(1'b1, 2'b00, 4'd5, 1'b0, 1'b1));
        chk("R10 start kept", int'(csr_rdata[0]), 1);
        wait_done();
        for (int c = 0; c < NCH; c++) exp_res[c] = fval(c, run);
        chk("R10 count", ncv, 16);
        check_order("R10 order", 15, ncv);
        check_bank("R10 bank");
        csr_read();
        csr_write(mk(1'b0, 2'b00, 4'd5, 1'b0, 1'b1));
        chk("R8 read-write clear", int'(csr_rdata[7]), 0);

        // R4: continuous scan, then stop.
        run++; ncv = 0;
        csr_write(mk(1'b1, 2'b11, 4'd2, 1'b0, 1'b1));
        while (ncv < 8) @(negedge clk);
        chk("R5 loop start held", int'(csr_rdata[0]), 1);
        chk("R4 pass done", int'(csr_rdata[7]), 1);
        csr_write(mk(1'b0, 2'b11, 4'd2, 1'b1, 1'b1));
        chk("R4 start reads 0", int'(csr_rdata[0]), 0);
        repeat (3 * LAT + 10) @(negedge clk);
        begin
            automatic int n1 = ncv;
            repeat (20) @(negedge clk);
            chk("R4 stopped", ncv, n1);
        end
        check_order("R4 order", 2, ncv);
        for (int c = 0; c <= 2; c++) exp_res[c] = fval(c, run);
        check_bank("R4 bank");
        pulse_dma();

        // R7/R2: reserved mode 01 with the enable cleared.
        run++; ncv = 0;
        csr_write(mk(1'b1, 2'b01, 4'd9, 1'b0, 1'b0));
        while (csr_rdata[0]) @(negedge clk);
        repeat (4) @(negedge clk);
        exp_res[9] = fval(9, run);
        chk("R2 mode01 count", ncv, 1);
        chk("R2 mode01 channel", log_ch[0], 9);
        chk("R7 done without ie", int'(csr_rdata[7]), 1);
        chk("R7 irq gated", int'(irq), 0);
        csr_write(mk(1'b0, 2'b01, 4'd9, 1'b1, 1'b1));
        chk("R7 irq on enable", int'(irq), 1);
        pulse_dma();
        chk("R9 dma clear2", int'(csr_rdata[7]), 0);
        check_bank("R6 final bank");

        finish_run();
    end

endmodule